// File: doc/BRIEF.md
# MDIO Clause 45 Management Master

This block is a register-driven management master that sends IEEE 802.3 Clause 45 frames to external PHYs over the two-wire MDIO/MDC pair. Software reaches it through a small 32-bit register port with four word slots. These slots hold the command word, the register-address word, the data word, and a combined configuration and status word. No separate go bit exists. A frame starts as a side effect of the register write that completes a step:

- A write to the address slot sends an address frame.
- A command write with the read flag set sends a read frame.
- A data write while the read flag is clear sends a write frame.

Software polls a shared busy flag between steps. It checks an error flag after a read. MDC comes from a programmable divider of the system clock. MDIO is brought out as a separate output, output enable and input, so that a pad or the surrounding logic can form the open line. All 64-bit frames start with 32 ones, then ST=00, then a two-bit opcode, the port address, the device address, two turnaround bits and a 16-bit field, sent most significant bit first.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset the block is idle: busy (slot 3 bit 31) reads 0, MDC is low and the MDIO output enable is low. Whenever no frame is in progress, MDC stays low and MDIO is released.
- R2: A write to slot 1 stores the word and sends an address frame. The frame has 32 ones, ST=00, OP=00, port address = command bits 9:5, device address = command bits 4:0, turnaround bits 1 then 0, and the written bits 15:0. A command write (slot 0) with bit 15 clear sends no frame.
- R3: A write to slot 2 while command bit 15 is clear sends a write frame with OP=01, turnaround bits 1 then 0, and the written bits 15:0. Slot 2 then reads back that value.
- R4: A write to slot 0 with bit 15 set stores the command and sends a read frame with OP=11, using the newly written addresses. The master releases MDIO for both turnaround bits and all 16 data bits (frame bits 46..63). When busy clears, slot 2 bits 15:0 hold the 16 bits sampled from the PHY, first sampled bit in bit 15.
- R5: Busy (slot 3 bit 31) is 1 from the clock after an accepted frame-starting write until the frame's last MDC period ends.
- R6: The error flag (slot 3 bit 30) is set when MDIO is high at the rising MDC edge of the second turnaround bit of a read frame. It is cleared when the next frame starts.
- R7: A write to slot 3 stores configuration bits 13:0, which read back in slot 3 bits 13:0. MDC high and low phases each last N system clocks, where N is configuration bits 13:6 shifted... precisely bits 13:7, with 0 treated as 1. The value 0xA48 gives N=20 and 0x3EC8 gives N=125. Reset gives N=20.
- R8: The MDIO output changes only on a falling MDC edge or at frame start, never while MDC is high. The read input is sampled on the rising MDC edge.
- R9: Register writes of any slot accepted while busy is 1 are ignored. They change no stored word and start no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Word slot: 0 command, 1 address, 2 data, 3 config/status |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the slot on regAddr (combinational) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO value driven by the master |
| mdioOe | output | 1 | MDIO output enable, high while the master drives |
| mdioIn | input | 1 | MDIO line value |

## Verification
The bench keeps the default divider width of 7 bits and the reset half-period of 20, and checks that reset value. It then reprograms the half-period to 2 so that most frames finish in a few hundred clocks. That leaves room for address, write, read and bad-turnaround reads, plus writes aimed at a busy block. A configuration of 0 reaches the clamp to a one-clock half-period. One frame each at the 20 and 125 settings confirms the two named rates.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;

  localparam logic [1:0] OP_ADDR  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b11;

  typedef struct packed {
    logic             load;
    logic             shift;
    logic             sample;
    logic             done;
    logic [IDX_W-1:0] bitIdx;
  } mdioStrb_t;
endpackage

// File: rtl/mdio_ctl.sv
module mdio_ctl
  import mdio_pkg::*;
#(
  parameter int HALF_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [HALF_W-1:0] halfCfg,
  output mdioStrb_t         strb,
  output logic              busy,
  output logic              mdc
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  logic [HALF_W-1:0] halfCnt;
  logic [HALF_W-1:0] halfM1;
  logic [IDX_W-1:0]  bitIdx;
  logic              tick;

  always_comb begin
    halfM1 = (halfCfg == '0) ? '0 : halfCfg - HALF_W'(1);
    tick   = busy && (halfCnt == halfM1);
    strb.load   = start;
    strb.sample = tick && !mdc;
    strb.shift  = tick && mdc && (bitIdx != LAST_IDX);
    strb.done   = tick && mdc && (bitIdx == LAST_IDX);
    strb.bitIdx = bitIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      mdc     <= 1'b0;
      halfCnt <= '0;
      bitIdx  <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      mdc     <= 1'b0;
      halfCnt <= '0;
      bitIdx  <= '0;
    end else if (busy) begin
      if (tick) begin
        halfCnt <= '0;
        mdc     <= ~mdc;
        if (strb.done) busy <= 1'b0;
        if (strb.shift) bitIdx <= bitIdx + IDX_W'(1);
      end else begin
        halfCnt <= halfCnt + HALF_W'(1);
      end
    end
  end
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  mdioStrb_t  strb,
  input  logic [1:0] loadOp,
  input  logic [4:0] loadPrt,
  input  logic [4:0] loadDev,
  input  logic [15:0] loadField,
  input  logic       mdioIn,
  output logic       mdioOut,
  output logic       mdioOe,
  output logic [15:0] rdShift,
  output logic       isRead,
  output logic       taErr
);
  logic [FRAME_BITS-1:0] frameSr;

  assign mdioOut = frameSr[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameSr <= '0;
      mdioOe  <= 1'b0;
      rdShift <= '0;
      isRead  <= 1'b0;
      taErr   <= 1'b0;
    end else if (strb.load) begin
      frameSr <= {{PRE_BITS{1'b1}}, 2'b00, loadOp, loadPrt, loadDev, 2'b10,
                  (loadOp == OP_READ) ? 16'h0000 : loadField};
      mdioOe  <= 1'b1;
      isRead  <= (loadOp == OP_READ);
      taErr   <= 1'b0;
    end else begin
      if (strb.shift) begin
        frameSr <= frameSr << 1;
        if (isRead && strb.bitIdx == IDX_W'(TA_FIRST - 1)) mdioOe <= 1'b0;
      end
      if (strb.done) mdioOe <= 1'b0;
      if (strb.sample && isRead) begin
        if (strb.bitIdx == IDX_W'(TA_FIRST + 1) && mdioIn) taErr <= 1'b1;
        if (strb.bitIdx >= IDX_W'(DATA_FIRST)) rdShift <= {rdShift[14:0], mdioIn};
      end
    end
  end
endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
  import mdio_pkg::*;
#(
  parameter int HALF_W   = 7,
  parameter int DEF_HALF = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  localparam int CFG_W = HALF_W + 7;
  localparam logic [CFG_W-1:0] CFG_RST = CFG_W'(DEF_HALF) << 7;

  logic [15:0]      cmdReg, addrReg, dataReg;
  logic [CFG_W-1:0] cfgReg;
  logic             busy, accept, start, isRead, taErr;
  logic [1:0]       loadOp;
  logic [4:0]       loadPrt, loadDev;
  logic [15:0]      rdShift;
  mdioStrb_t        strb;

  always_comb begin
    accept  = regWrEn && !busy;
    start   = 1'b0;
    loadOp  = OP_ADDR;
    loadPrt = cmdReg[9:5];
    loadDev = cmdReg[4:0];
    if (accept) begin
      case (regAddr)
        2'd0: if (regWrData[15]) begin
          start   = 1'b1;
          loadOp  = OP_READ;
          loadPrt = regWrData[9:5];
          loadDev = regWrData[4:0];
        end
        2'd1: start = 1'b1;
        2'd2: if (!cmdReg[15]) begin
          start  = 1'b1;
          loadOp = OP_WRITE;
        end
        default: start = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg  <= '0;
      addrReg <= '0;
      dataReg <= '0;
      cfgReg  <= CFG_RST;
    end else begin
      if (accept) begin
        case (regAddr)
          2'd0: cmdReg  <= regWrData[15:0];
          2'd1: addrReg <= regWrData[15:0];
          2'd2: dataReg <= regWrData[15:0];
          default: cfgReg <= regWrData[CFG_W-1:0];
        endcase
      end
      if (strb.done && isRead) dataReg <= rdShift;
    end
  end

  always_comb begin
    case (regAddr)
      2'd0:    regRdData = {16'h0, cmdReg};
      2'd1:    regRdData = {16'h0, addrReg};
      2'd2:    regRdData = {16'h0, dataReg};
      default: regRdData = {busy, taErr, (30 - CFG_W)'(0), cfgReg};
    endcase
  end

  mdio_ctl #(.HALF_W(HALF_W)) i_ctl (
    .clk(clk), .rstN(rstN), .start(start), .halfCfg(cfgReg[CFG_W-1:7]),
    .strb(strb), .busy(busy), .mdc(mdc)
  );

  mdio_dp i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadOp(loadOp), .loadPrt(loadPrt),
    .loadDev(loadDev), .loadField(regWrData[15:0]), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .rdShift(rdShift), .isRead(isRead),
    .taErr(taErr)
  );
endmodule

// File: rtl/mdio_c45_master_chk.sv
module mdio_c45_master_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        mdc,
  input logic        mdioOe,
  input logic        mdioOut,
  input logic        taErr,
  input logic [15:0] cmdReg,
  input logic [15:0] addrReg
);
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdioOe && !mdc));

  assert_start_mdc_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !mdc);

  assert_out_on_fall_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$stable(mdioOut)) |-> !mdc);

  assert_err_clear_on_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !taErr);

  assert_cmd_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(cmdReg));

  assert_addr_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(addrReg));
endmodule

bind mdio_c45_master mdio_c45_master_chk i_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .mdc(mdc), .mdioOe(mdioOe),
  .mdioOut(mdioOut), .taErr(taErr), .cmdReg(cmdReg), .addrReg(addrReg)
);

// File: tb/test_mdio_c45_master.sv
module test_mdio_c45_master;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic mdc, mdioOut, mdioOe, mdioIn;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  // PHY responder state
  logic phyOe = 1'b0, phyOut = 1'b1, phyBadTa = 1'b0;
  logic [15:0] phyData = 16'h0;
  logic [63:0] frm = '0;
  int rcnt = 0;
  bit curRead = 1'b0;
  int framesSeen = 0;
  int oeViol = 0;
  logic [63:0] expQ[$];

  assign mdioIn = mdioOe ? mdioOut : (phyOe ? phyOut : 1'b1);

  mdio_c45_master i_mdio_c45_master (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mkFrame(input logic [1:0] op, input logic [4:0] prt,
      input logic [4:0] dev, input logic [1:0] ta, input logic [15:0] fld);
    return {32'hFFFF_FFFF, 2'b00, op, prt, dev, ta, fld};
  endfunction

  // monitor: collect line bits on rising MDC, compare with scoreboard
  always @(posedge mdc) begin
    logic [63:0] nf;
    nf = {frm[62:0], mdioIn};
    if (curRead && rcnt >= 46 && mdioOe) oeViol++;
    frm = nf;
    rcnt = rcnt + 1;
    if (rcnt == 36) curRead = (nf[1:0] == 2'b11);
    if (rcnt == 64) begin
      framesSeen++;
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9 unexpected frame actual=%h expected=none", nf);
      end else begin
        check("R2/R3/R4 frame content", nf, expQ.pop_front());
      end
      rcnt = 0;
      curRead = 1'b0;
    end
  end

  // PHY drive on falling MDC
  always @(negedge mdc) begin
    if (curRead && rcnt == 47) begin
      phyOe = 1'b1; phyOut = phyBadTa ? 1'b1 : 1'b0;
    end else if (curRead && rcnt >= 48 && rcnt <= 63) begin
      phyOe = 1'b1; phyOut = phyData[63 - rcnt];
    end else begin
      phyOe = 1'b0; phyOut = 1'b1;
    end
  end

  // MDC high-phase length and MDIO change rule, sampled mid-cycle
  int hiRun = 0, lastHi = 0, chgViol = 0;
  logic prevOut = 1'b0;
  always @(negedge clk) begin
    if (mdc) hiRun++;
    else if (hiRun != 0) begin lastHi = hiRun; hiRun = 0; end
    if (mdc && mdioOe && mdioOut !== prevOut) chgViol++;
    prevOut = mdioOut;
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    for (int i = 0; i < 40000; i++) begin
      rd(2'd3, s);
      if (!s[31]) return;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [15:0] cmdA;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    rd(2'd3, v);
    check("R1 busy after reset", v[31], 1'b0);
    check("R7 reset config", v[13:0], 14'hA00);
    check("R1 mdc/oe after reset", {mdc, mdioOe}, 2'b00);

    wr(2'd3, 32'h0000_0148);
    rd(2'd3, v);
    check("R7 config readback", v[13:0], 14'h0148);

    cmdA = 16'h0267; // prt 0x13, dev 0x07, bit15 clear
    wr(2'd0, {16'h0, cmdA});
    rd(2'd3, v);
    check("R2 command write without flag starts nothing", v[31], 1'b0);

    expQ.push_back(mkFrame(2'b00, 5'h13, 5'h07, 2'b10, 16'hBEEF));
    wr(2'd1, 32'h0000_BEEF);
    rd(2'd3, v);
    check("R5 busy during address frame", v[31], 1'b1);
    wr(2'd1, 32'h0000_5555);  // ignored
    wr(2'd0, 32'h0000_8000);  // ignored, would be a read
    waitIdle();
    rd(2'd0, v);
    check("R9 command unchanged by busy write", v[15:0], cmdA);
    rd(2'd1, v);
    check("R9 address unchanged by busy write", v[15:0], 16'hBEEF);
    check("R7 mdc high phase half=2", lastHi, 2);

    expQ.push_back(mkFrame(2'b01, 5'h13, 5'h07, 2'b10, 16'h1234));
    wr(2'd2, 32'h0000_1234);
    waitIdle();
    rd(2'd2, v);
    check("R3 data readback after write frame", v[15:0], 16'h1234);

    phyData = 16'hA5C3; phyBadTa = 1'b0;
    expQ.push_back(mkFrame(2'b11, 5'h0A, 5'h1E, 2'b10, 16'hA5C3));
    wr(2'd0, {16'h0, 1'b1, 5'h0, 5'h0A, 5'h1E});
    waitIdle();
    rd(2'd2, v);
    check("R4 read data returned", v[15:0], 16'hA5C3);
    rd(2'd3, v);
    check("R6 no error on good turnaround", v[30], 1'b0);
    check("R4 master released line during read", oeViol, 0);

    phyData = 16'h0F0F; phyBadTa = 1'b1;
    expQ.push_back(mkFrame(2'b11, 5'h01, 5'h02, 2'b11, 16'h0F0F));
    wr(2'd0, {16'h0, 1'b1, 5'h0, 5'h01, 5'h02});
    waitIdle();
    rd(2'd3, v);
    check("R6 error on bad turnaround", v[30], 1'b1);
    phyBadTa = 1'b0;

    // command still has bit15 set: data write must not start a frame
    wr(2'd2, 32'h0000_7777);
    rd(2'd3, v);
    check("R3 data write with read flag starts nothing", v[31], 1'b0);

    expQ.push_back(mkFrame(2'b00, 5'h01, 5'h02, 2'b10, 16'h0042));
    wr(2'd1, 32'h0000_0042);
    rd(2'd3, v);
    check("R6 error cleared at next frame", v[30], 1'b0);
    waitIdle();

    wr(2'd0, 32'h0000_0000);
    wr(2'd3, 32'h0000_0000);
    expQ.push_back(mkFrame(2'b01, 5'h00, 5'h00, 2'b10, 16'hC001));
    wr(2'd2, 32'h0000_C001);
    waitIdle();
    check("R7 half-period clamps to 1", lastHi, 1);

    wr(2'd3, 32'h0000_0A48);
    expQ.push_back(mkFrame(2'b00, 5'h00, 5'h00, 2'b10, 16'h0101));
    wr(2'd1, 32'h0000_0101);
    waitIdle();
    check("R7 0xA48 gives 20 clocks", lastHi, 20);

    wr(2'd3, 32'h0000_3EC8);
    expQ.push_back(mkFrame(2'b00, 5'h00, 5'h00, 2'b10, 16'h0202));
    wr(2'd1, 32'h0000_0202);
    waitIdle();
    check("R7 0x3EC8 gives 125 clocks", lastHi, 125);

    repeat (10) @(negedge clk);
    check("R1 idle state after frames", {mdc, mdioOe}, 2'b00);
    check("R8 no MDIO change while MDC high", chgViol, 0);
    check("R9 frames seen", framesSeen, 8);
    check("R2 scoreboard drained", expQ.size(), 0);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule